// File: doc/BRIEF.md
# System Control and Status Register

This block is a single 16-bit register that sits at one word-aligned address. A read returns a status view and a write loads a separate control view, so the same address reaches two different registers. Only half-word accesses are accepted. Byte and word accesses are dropped: they change nothing and return no data.

The status view combines three kinds of bits:
- Two sticky event bits. The first is a video event, set while the second area-detect input is high. The second is a memory error, set on a bus timeout during a write. Both are cleared by writing one to their position, and both feed one shared level-1 interrupt.
- Three colour-comparator samples. These follow their inputs only while the first area-detect input is high, and hold otherwise.
- Echo bits. Some mirror control bits that software wrote. Others mirror a cursor test flop and a manufacturing jumper.

The control view drives four outputs: an active-low LED field, a serial-driver disable, a parity-check disable and a self-test status pin.

There is no sequencing state. Every bit is an independent flop or a wire. The only timing is one clock edge from a stimulus to the visible result.

Top module: `sys_csr`

## Requirements
- R1: After reset the control view is all zero. So `led_ctl` is 4'b0000 (all LEDs lit), and `serial_tx_disable`, `parity_check_disable` and `selftest_pin` are 0. All sticky bits and comparator samples read 0.
- R2: A write is taken only when `bus_sel`=1, `bus_wr`=1 and `bus_size`=2'b01 (half-word). The control layout is:
  - [15:12] LED field
  - [3] serial disable
  - [8] parity disable
  - [9] status pin

  The control outputs follow on the next edge. A write with any other `bus_size` (2'b00 byte, 2'b10 word) leaves every output and status bit unchanged.
- R3: A half-word read (`bus_sel`=1, `bus_wr`=0, `bus_size`=2'b01) puts the status view on `bus_rdata` with `bus_rvalid`=1 one edge later. The status layout is:
  - [0] red>blue
  - [1] red>green
  - [2] blue>green
  - [3] serial disable echo
  - [4] video event
  - [5] memory error
  - [7] cursor test
  - [8] parity disable echo
  - [9] status echo
  - [10] jumper

  All other bits read 0. A read of any other size gives `bus_rvalid`=0 and `bus_rdata`=0.
- R4: `area2_hit`=1 sets status bit 4 on the next edge. The bit then stays set until it is cleared.
- R5: `wr_timeout`=1 sets status bit 5 on the next edge. The bit then stays set until it is cleared.
- R6: An accepted write with bit 4 or bit 5 equal to 1 clears that status bit. A 0 in that position leaves the bit unchanged.
- R7: When a set event and a clearing write reach the same bit in the same cycle, the bit ends set.
- R8: `irq_lvl1` is 1 exactly when status bit 4 or status bit 5 is 1.
- R9: Status bits [2:0] load the comparator inputs on each edge where `area1_hit`=1, and hold on every other edge.
- R10: Status bits 3, 8 and 9 echo the control bits 3, 8 and 9. Status bit 7 mirrors `cursor_test_in` and bit 10 mirrors `jumper_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register selected this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| bus_wdata | input | 16 | Write data (control view) |
| bus_rdata | output | 16 | Read data (status view) |
| bus_rvalid | output | 1 | Read data valid |
| cmp_r_gt_b | input | 1 | Red DAC above blue |
| cmp_r_gt_g | input | 1 | Red DAC above green |
| cmp_b_gt_g | input | 1 | Blue DAC above green |
| area1_hit | input | 1 | First area-detect output, comparator sample enable |
| area2_hit | input | 1 | Second area-detect output, video event |
| wr_timeout | input | 1 | Bus timeout on a write |
| jumper_in | input | 1 | Manufacturing jumper |
| cursor_test_in | input | 1 | Cursor test flop state |
| led_ctl | output | 4 | LED drive, 0 lights an LED |
| serial_tx_disable | output | 1 | Disables serial line drivers |
| parity_check_disable | output | 1 | Disables memory parity checks |
| selftest_pin | output | 1 | Self-test status pin |
| irq_lvl1 | output | 1 | Shared level-1 interrupt |

## Verification
A wrong sticky bit shows at two ports at once: `irq_lvl1` on the edge after the event or clear, and the next status read one edge after that. A lost clear leaves the interrupt stuck high, and a lost set-wins rule drops an event that arrived during a clear. A comparator sample that leaks through while `area1_hit` is low shows up on the first read after the comparator inputs change. A control bit that is written wrongly, or taken from a non-half-word access, shows on its output pin one edge after the write and in its echo bit on the following read.

// File: rtl/sys_csr_pkg.sv
package sys_csr_pkg;
    localparam int DATA_W   = 16;
    localparam int LED_W    = 4;
    localparam int LED_LSB  = 12;
    localparam int CMP_N    = 3;
    localparam int B_TXDIS  = 3;
    localparam int B_VINT   = 4;
    localparam int B_MERR   = 5;
    localparam int B_CURS   = 7;
    localparam int B_PARD   = 8;
    localparam int B_STAT   = 9;
    localparam int B_JUMP   = 10;
    localparam int EVT_N    = 2;
    localparam logic [1:0] SZ_HALF = 2'b01;

    typedef struct packed {
        logic [LED_W-1:0] led;
        logic             txdis;
        logic             pardis;
        logic             stat;
    } ctl_t;
endpackage

// File: rtl/csr_sticky_flag.sv
module csr_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (set_i)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/csr_cmp_sampler.sv
module csr_cmp_sampler #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q_o[i] <= 1'b0;
            else if (en_i)
                q_o[i] <= d_i[i];
        end
    end

    assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(q_o));
    assert_gate_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/sys_csr.sv
module sys_csr
    import sys_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              cmp_r_gt_b,
    input  logic              cmp_r_gt_g,
    input  logic              cmp_b_gt_g,
    input  logic              area1_hit,
    input  logic              area2_hit,
    input  logic              wr_timeout,
    input  logic              jumper_in,
    input  logic              cursor_test_in,
    output logic [LED_W-1:0]  led_ctl,
    output logic              serial_tx_disable,
    output logic              parity_check_disable,
    output logic              selftest_pin,
    output logic              irq_lvl1
);
    localparam int EVT_VINT = 0;
    localparam int EVT_MERR = 1;

    logic              half_ok;
    logic              wr_take;
    logic              rd_take;
    ctl_t              ctl_q;
    logic [CMP_N-1:0]  cmp_q;
    logic [EVT_N-1:0]  evt_set;
    logic [EVT_N-1:0]  evt_clr;
    logic [EVT_N-1:0]  evt_q;
    logic [DATA_W-1:0] status_view;

    assign half_ok = (bus_size == SZ_HALF);
    assign wr_take = bus_sel &&  bus_wr && half_ok;
    assign rd_take = bus_sel && !bus_wr && half_ok;

    // Control view: cleared at reset, loaded by accepted writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_take) begin
            ctl_q.led    <= bus_wdata[LED_LSB +: LED_W];
            ctl_q.txdis  <= bus_wdata[B_TXDIS];
            ctl_q.pardis <= bus_wdata[B_PARD];
            ctl_q.stat   <= bus_wdata[B_STAT];
        end
    end

    // Sticky events, one flag per source
    assign evt_set[EVT_VINT] = area2_hit;
    assign evt_set[EVT_MERR] = wr_timeout;
    assign evt_clr[EVT_VINT] = wr_take && bus_wdata[B_VINT];
    assign evt_clr[EVT_MERR] = wr_take && bus_wdata[B_MERR];

    for (genvar e = 0; e < EVT_N; e++) begin : g_evt
        csr_sticky_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (evt_set[e]),
            .clr_i  (evt_clr[e]),
            .flag_o (evt_q[e])
        );
    end

    csr_cmp_sampler #(.N(CMP_N)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (area1_hit),
        .d_i   ({cmp_b_gt_g, cmp_r_gt_g, cmp_r_gt_b}),
        .q_o   (cmp_q)
    );

    always_comb begin
        status_view               = '0;
        status_view[CMP_N-1:0]    = cmp_q;
        status_view[B_TXDIS]      = ctl_q.txdis;
        status_view[B_VINT]       = evt_q[EVT_VINT];
        status_view[B_MERR]       = evt_q[EVT_MERR];
        status_view[B_CURS]       = cursor_test_in;
        status_view[B_PARD]       = ctl_q.pardis;
        status_view[B_STAT]       = ctl_q.stat;
        status_view[B_JUMP]       = jumper_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_take;
            bus_rdata  <= rd_take ? status_view : '0;
        end
    end

    assign led_ctl              = ctl_q.led;
    assign serial_tx_disable    = ctl_q.txdis;
    assign parity_check_disable = ctl_q.pardis;
    assign selftest_pin         = ctl_q.stat;
    assign irq_lvl1             = |evt_q;

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_lvl1) |-> $past(area2_hit || wr_timeout));
    assert_irq_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_lvl1) |-> $past(wr_take));
    assert_size_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !half_ok) |=>
            ($stable(led_ctl) && $stable(serial_tx_disable) &&
             $stable(parity_check_disable) && $stable(selftest_pin)));
    assert_read_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(rd_take));
endmodule

// File: tb/tb_sys_csr.sv
module tb_sys_csr;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'b01;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_rvalid;
    logic        cmp_r_gt_b = 0, cmp_r_gt_g = 0, cmp_b_gt_g = 0;
    logic        area1_hit = 0, area2_hit = 0, wr_timeout = 0;
    logic        jumper_in = 0, cursor_test_in = 0;
    logic [3:0]  led_ctl;
    logic        serial_tx_disable, parity_check_disable, selftest_pin, irq_lvl1;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sys_csr dut (.*);

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d, input logic [1:0] sz = 2'b01);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; bus_size = 2'b01;
    endtask

    task automatic rd(output logic [15:0] d, output logic v, input logic [1:0] sz = 2'b01);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_size = sz;
        @(negedge clk);
        bus_sel = 0;
        d = bus_rdata; v = bus_rvalid;
        bus_size = 2'b01;
    endtask

    task automatic t_reset;
        logic [15:0] d; logic v;
        check("R1 led", {12'h0, led_ctl}, 16'h0);
        check("R1 outs", {13'h0, serial_tx_disable, parity_check_disable, selftest_pin}, 16'h0);
        check("R1 irq", {15'h0, irq_lvl1}, 16'h0);
        rd(d, v);
        check("R1 status", d, 16'h0000);
        check("R3 rvalid", {15'h0, v}, 16'h1);
    endtask

    task automatic t_control;
        logic [15:0] d; logic v;
        wr(16'hA308);
        check("R2 led", {12'h0, led_ctl}, 16'h000A);
        check("R2 outs", {13'h0, serial_tx_disable, parity_check_disable, selftest_pin}, 16'h7);
        rd(d, v);
        check("R10 echo", d, 16'h0308);
        wr(16'h5000, 2'b00);
        check("R2 byte ignored", {12'h0, led_ctl}, 16'h000A);
        wr(16'h0000, 2'b10);
        check("R2 word ignored", {13'h0, serial_tx_disable, parity_check_disable, selftest_pin}, 16'h7);
        rd(d, v, 2'b10);
        check("R3 word read", {v, d[14:0]}, 16'h0);
        wr(16'h3000);
        check("R2 reload", {11'h0, led_ctl, serial_tx_disable}, 16'h0006);
    endtask

    task automatic t_events;
        logic [15:0] d; logic v;
        @(negedge clk); area2_hit = 1;
        @(negedge clk); area2_hit = 0;
        check("R4 irq", {15'h0, irq_lvl1}, 16'h1);
        repeat (3) @(negedge clk);
        rd(d, v);
        check("R4 sticky", d & 16'h0030, 16'h0010);
        @(negedge clk); wr_timeout = 1;
        @(negedge clk); wr_timeout = 0;
        rd(d, v);
        check("R5 memerr", d & 16'h0030, 16'h0030);
        wr(16'h3000 | 16'h0020);
        rd(d, v);
        check("R6 clear merr only", d & 16'h0030, 16'h0010);
        check("R8 irq one bit", {15'h0, irq_lvl1}, 16'h1);
        wr(16'h3000);
        check("R6 zero no effect", {15'h0, irq_lvl1}, 16'h1);
        wr(16'h3010);
        check("R8 irq low", {15'h0, irq_lvl1}, 16'h0);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_size = 2'b01; bus_wdata = 16'h3030; wr_timeout = 1;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0; wr_timeout = 0;
        rd(d, v);
        check("R7 set wins", d & 16'h0030, 16'h0020);
        wr(16'h3030, 2'b00);
        check("R6 byte no clear", {15'h0, irq_lvl1}, 16'h1);
        wr(16'h3030);
        check("R8 irq cleared", {15'h0, irq_lvl1}, 16'h0);
    endtask

    task automatic t_sampler;
        logic [15:0] d; logic v;
        @(negedge clk); cmp_r_gt_b = 1; cmp_b_gt_g = 1;
        rd(d, v);
        check("R9 hold no strobe", d & 16'h0007, 16'h0000);
        @(negedge clk); area1_hit = 1;
        @(negedge clk); area1_hit = 0; cmp_r_gt_b = 0; cmp_r_gt_g = 1; cmp_b_gt_g = 0;
        rd(d, v);
        check("R9 sampled", d & 16'h0007, 16'h0005);
        @(negedge clk); area1_hit = 1;
        @(negedge clk); area1_hit = 0;
        rd(d, v);
        check("R9 resampled", d & 16'h0007, 16'h0002);
    endtask

    task automatic t_mirror;
        logic [15:0] d; logic v;
        @(negedge clk); jumper_in = 1; cursor_test_in = 1;
        rd(d, v);
        check("R10 mirrors", d & 16'h0480, 16'h0480);
        @(negedge clk); jumper_in = 0;
        rd(d, v);
        check("R10 jumper low", d & 16'h0480, 16'h0080);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_control();
        t_events();
        t_sampler();
        t_mirror();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule